// File: doc/BRIEF.md
# DAC Conversion Trigger and Data Controller

This block is the digital front end of a 12-bit digital-to-analog converter. Software programs it through a small word-addressed register port. The port holds a control word, a data word, a one-shot software trigger, a status word and a settling-delay count. When a conversion starts, the block takes a 12-bit code from the data word, using either the low or the upper-middle bit field, and drives it onto the converter bus. The code then stays on the bus until the next conversion.

A conversion starts on one of several events. With trigger mode off, it starts on a write of the data word. With trigger mode on, a 3-bit source field chooses the event: the software trigger bit, an external pin, one of four timer inputs or one of two PWM inputs. The pin can be used as a low level, a high level, a falling edge or a rising edge. After a start the block reports busy for a programmed number of cycles and then sets a finish flag, which can raise the interrupt. Triggers from hardware sources can also raise a DMA request. A data write answers that request. A new hardware trigger that arrives while a request is still unanswered sets an under-run flag.

The interface has no data stream with back-pressure. Register writes are accepted in the cycle they appear, reads are combinational, and all other pins are plain levels or pulses.

Top module: `dac_trg_ctrl`

## Requirements
- R1: With trigger enable (control bit 0) clear, a write to the data word (address 1) starts a conversion. The new code is on `dac_code` one clock after the write edge, and `dac_code` changes at no other time.
- R2: With trigger enable set and source 0, writing 1 to bit 0 of address 2 starts a conversion. The bit reads back as 0, and a data write alone starts nothing.
- R3: Source codes 2 to 5 select the rising edge of timer inputs 0 to 3, and codes 6 and 7 select the rising edge of PWM inputs 0 and 1. Edges on inputs that are not selected start nothing.
- R4: Source 1 selects the external pin. Pin mode (control bits 9:8) 0 triggers on a low level, 1 on a high level, 2 on a falling edge and 3 on a rising edge. The pin passes through a two-flop synchronizer first.
- R5: With left-align (control bit 1) clear, the code is data bits 11:0.
- R6: With left-align set, the code is data bits 15:4.
- R7: Busy lasts N cycles after a start, where N is the delay word at address 4 (a value of 0 acts as 1). Triggers that arrive while busy are dropped.
- R8: Status bit 0 (finish) sets when busy ends and is cleared by writing 1 to it; writing 0 leaves it set. When finish interrupt enable (control bit 3) is set, `irq` follows the flag.
- R9: A level trigger that stays active starts a new conversion each time the previous one ends, and stops once the level goes inactive.
- R10: With DMA enable (control bit 2) set, each started hardware-source conversion raises `dma_req`. A data write clears it. Starts from a data write or from the software bit raise no request.
- R11: Status bit 1 (under-run) sets when a hardware trigger starts a conversion while `dma_req` is still pending. Writing 1 to it clears it, and under-run enable (control bit 4) routes it to `irq`.
- R12: Status bit 8 and `busy` read 1 during a conversion and 0 when the block is idle. All flags, outputs and registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address (0 control, 1 data, 2 software trigger, 3 status, 4 delay) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| tmr_evt | input | 4 | Timer trigger inputs |
| pwm_evt | input | 2 | PWM trigger inputs |
| dac_code | output | 12 | Code driven to the converter |
| busy | output | 1 | Conversion settling in progress |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request, held until a data write |

## Verification
The conversion start is exercised from every kind of source: a direct data write, the software bit, a selected and an unselected timer, a selected and an unselected PWM input, and the pin in all four modes. Each unselected or inactive case is followed by a check that the code did not change, which shows that only the chosen event starts a conversion. Holding a level active shows the repeated restart, and a delay of zero and a write made while busy show the boundaries of the busy window. DMA sequences with and without an answering data write tell a correctly answered request apart from an under-run.

// File: rtl/dac_trg_pkg.sv
package dac_trg_pkg;
  localparam int ADDR_W = 3;
  localparam int N_TMR  = 4;
  localparam int N_PWM  = 2;
  localparam int N_HW   = 1 + N_TMR + N_PWM;   // pin, timers, pwm

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_DATA  = 3'd1,
    A_SWTRG = 3'd2,
    A_STAT  = 3'd3,
    A_DELAY = 3'd4
  } reg_addr_e;

  localparam logic [2:0] SRC_SW  = 3'd0;
  localparam logic [2:0] SRC_PIN = 3'd1;

  localparam logic [1:0] PIN_LOW  = 2'd0;
  localparam logic [1:0] PIN_HIGH = 2'd1;
  localparam logic [1:0] PIN_FALL = 2'd2;
  localparam logic [1:0] PIN_RISE = 2'd3;

  typedef struct packed {
    logic [1:0] pin_mode;  // 9:8
    logic [2:0] src;       // 7:5
    logic       udr_ie;    // 4
    logic       fin_ie;    // 3
    logic       dma_en;    // 2
    logic       left_al;   // 1
    logic       trig_en;   // 0
  } ctrl_t;
endpackage

// File: rtl/dac_trg_sync.sv
module dac_trg_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[g] <= '0;
      else if (g == 0) stage_q[g] <= async_in;
      else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign lvl = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/dac_trg_sel.sv
module dac_trg_sel
  import dac_trg_pkg::*;
#(
  parameter int NHW = N_HW
) (
  input  logic           trig_en,
  input  logic [2:0]     src,
  input  logic [1:0]     pin_mode,
  input  logic           data_wr,
  input  logic           sw_pulse,
  input  logic           pin_lvl,
  input  logic           pin_fall,
  input  logic [NHW-1:0] hw_rise,
  output logic           evt,
  output logic           hw_src
);
  always_comb begin
    evt    = 1'b0;
    hw_src = trig_en && (src != SRC_SW);
    if (!trig_en) begin
      evt = data_wr;
    end else if (src == SRC_SW) begin
      evt = sw_pulse;
    end else if (src == SRC_PIN) begin
      case (pin_mode)
        PIN_LOW:  evt = ~pin_lvl;
        PIN_HIGH: evt = pin_lvl;
        PIN_FALL: evt = pin_fall;
        default:  evt = hw_rise[0];
      endcase
    end else begin
      evt = hw_rise[src - 3'd1];
    end
  end
endmodule

// File: rtl/dac_trg_settle.sv
module dac_trg_settle #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] delay,
  output logic             busy,
  output logic             done
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= (delay == '0) ? DLY_W'(1) : delay;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == DLY_W'(1));

  // R7: a start is only taken while idle
  a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R7: busy follows every start
  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/dac_trg_ctrl.sv
module dac_trg_ctrl
  import dac_trg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CODE_W      = 12,
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_pin,
  input  logic [N_TMR-1:0]  tmr_evt,
  input  logic [N_PWM-1:0]  pwm_evt,
  output logic [CODE_W-1:0] dac_code,
  output logic              busy,
  output logic              irq,
  output logic              dma_req
);
  localparam int LEFT_OFS = 16 - CODE_W;
  localparam int CTRL_W   = $bits(ctrl_t);

  ctrl_t              ctrl_q;
  logic [DATA_W-1:0]  data_q;
  logic [DLY_W-1:0]   delay_q;
  logic               fin_q, udr_q, dma_q, data_wr_q, sw_q;
  logic [CODE_W-1:0]  code_q;

  logic wr_ctrl, wr_data, wr_sw, wr_stat, wr_dly;
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_sw   = bus_wr && (bus_addr == A_SWTRG);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_dly  = bus_wr && (bus_addr == A_DELAY);

  logic [N_HW-1:0] s_lvl, s_rise, s_fall;
  logic            sync_unused;
  assign sync_unused = ^{s_lvl[N_HW-1:1], s_fall[N_HW-1:1]};

  dac_trg_sync #(.W(N_HW), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .async_in({pwm_evt, tmr_evt, ext_pin}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  logic evt, hw_src, start, done;

  dac_trg_sel sel_i (
    .trig_en(ctrl_q.trig_en), .src(ctrl_q.src), .pin_mode(ctrl_q.pin_mode),
    .data_wr(data_wr_q), .sw_pulse(sw_q),
    .pin_lvl(s_lvl[0]), .pin_fall(s_fall[0]), .hw_rise(s_rise),
    .evt(evt), .hw_src(hw_src)
  );

  assign start = evt && !busy;

  dac_trg_settle #(.DLY_W(DLY_W)) settle_i (
    .clk(clk), .rst_n(rst_n), .start(start), .delay(delay_q),
    .busy(busy), .done(done)
  );

  logic dma_start;
  assign dma_start = start && hw_src && ctrl_q.dma_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      data_q    <= '0;
      delay_q   <= '0;
      fin_q     <= 1'b0;
      udr_q     <= 1'b0;
      dma_q     <= 1'b0;
      data_wr_q <= 1'b0;
      sw_q      <= 1'b0;
      code_q    <= '0;
    end else begin
      data_wr_q <= wr_data;
      sw_q      <= wr_sw && bus_wdata[0];
      if (wr_ctrl) ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_data) data_q  <= bus_wdata;
      if (wr_dly)  delay_q <= bus_wdata[DLY_W-1:0];
      if (start)
        code_q <= ctrl_q.left_al ? data_q[LEFT_OFS +: CODE_W] : data_q[CODE_W-1:0];
      if (done)                          fin_q <= 1'b1;
      else if (wr_stat && bus_wdata[0])  fin_q <= 1'b0;
      if (dma_start && dma_q && !wr_data) udr_q <= 1'b1;
      else if (wr_stat && bus_wdata[1])   udr_q <= 1'b0;
      if (dma_start)    dma_q <= 1'b1;
      else if (wr_data) dma_q <= 1'b0;
    end
  end

  assign dac_code = code_q;
  assign dma_req  = dma_q;
  assign irq      = (fin_q && ctrl_q.fin_ie) || (udr_q && ctrl_q.udr_ie);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      A_DATA:  bus_rdata = data_q;
      A_STAT:  bus_rdata = DATA_W'({busy, 6'b0, udr_q, fin_q});
      A_DELAY: bus_rdata = DATA_W'(delay_q);
      default: bus_rdata = '0;
    endcase
  end

  // R1: the code only moves on a start
  a_r1_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(dac_code));
  // R8: finish appears as busy ends
  a_r8_fin_at_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_q) |-> $fell(busy));
  // R10: a data write answers the request
  a_r10_req_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !start) |=> !dma_req);
  // R11: under-run only with a pending request
  a_r11_udr_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udr_q) |-> $past(dma_req));
endmodule

// File: tb/dac_trg_ctrl_tb_top.sv
module dac_trg_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_pin = 1'b0;
  logic [3:0]  tmr_evt = '0;
  logic [1:0]  pwm_evt = '0;
  logic [11:0] dac_code;
  logic        busy, irq, dma_req;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  dac_trg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .tmr_evt(tmr_evt), .pwm_evt(pwm_evt), .dac_code(dac_code),
    .busy(busy), .irq(irq), .dma_req(dma_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic pulse_tmr(input int idx);
    @(negedge clk); tmr_evt[idx] = 1'b1; tick(2); tmr_evt[idx] = 1'b0;
  endtask

  task automatic pulse_pwm(input int idx);
    @(negedge clk); pwm_evt[idx] = 1'b1; tick(2); pwm_evt[idx] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R12 reset code", 32'(dac_code), 0);
    check("R12 reset busy", 32'(busy), 0);
    check("R12 reset irq", 32'(irq), 0);
    check("R12 reset dma_req", 32'(dma_req), 0);
    rd(3, v); check("R12 reset status", v, 0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    int n;
    wr(4, 5);
    wr(0, 0);
    wr(1, 32'hABCD_E123);
    check("R1 code not yet updated", 32'(dac_code), 0);
    tick(1);
    check("R5 right-aligned code", 32'(dac_code), 32'h123);
    rd(3, v); check("R12 status busy bit", v[8], 1);
    n = 0;
    while (busy === 1'b1 && n < 50) begin n++; @(negedge clk); end
    check("R7 busy length N=5", n, 5);
    rd(3, v); check("R8 finish set", v, 1);
    check("R12 idle after conversion", v[8], 0);
    check("R8 irq off without enable", 32'(irq), 0);
  endtask

  task automatic t_left();
    wr(0, 2);
    wr(1, 32'hFFFF_5A7C);
    tick(2);
    check("R6 left-aligned code", 32'(dac_code), 32'h5A7);
    wait_idle();
    wr(0, 0);
  endtask

  task automatic t_busy_ignore();
    int n;
    wr(4, 6);
    wr(1, 32'h111);
    tick(1);
    wr(1, 32'h222);
    wait_idle(); tick(2);
    check("R7 write during busy dropped", 32'(dac_code), 32'h111);
    wr(4, 0);
    wr(1, 32'h333);
    tick(1);
    n = 0;
    while (busy === 1'b1 && n < 50) begin n++; @(negedge clk); end
    check("R7 delay 0 acts as 1", n, 1);
    check("R7 code after delay 0", 32'(dac_code), 32'h333);
  endtask

  task automatic t_fin_irq();
    logic [31:0] v;
    wr(0, 8);
    tick(1);
    check("R8 irq with finish enabled", 32'(irq), 1);
    wr(3, 0);
    rd(3, v); check("R8 write 0 keeps finish", v[0], 1);
    wr(3, 1);
    rd(3, v); check("R8 W1C clears finish", v[0], 0);
    check("R8 irq drops after clear", 32'(irq), 0);
  endtask

  task automatic t_sw();
    logic [31:0] v;
    wr(4, 2);
    wr(0, 1);
    wr(1, 32'h0AA);
    tick(3);
    check("R2 data write alone does not start", 32'(dac_code), 32'h333);
    wr(2, 1);
    rd(2, v); check("R2 trigger bit reads 0", v, 0);
    tick(1);
    check("R2 software trigger code", 32'(dac_code), 32'h0AA);
    wait_idle();
  endtask

  task automatic t_timer_pwm();
    wr(0, 1 | (3 << 5));
    wr(1, 32'h0B1);
    pulse_tmr(0); tick(6);
    check("R3 unselected timer ignored", 32'(dac_code), 32'h0AA);
    pulse_tmr(1); tick(6);
    check("R3 timer 1 trigger", 32'(dac_code), 32'h0B1);
    wait_idle();
    wr(0, 1 | (7 << 5));
    wr(1, 32'h0C2);
    pulse_pwm(0); tick(6);
    check("R3 unselected pwm ignored", 32'(dac_code), 32'h0B1);
    pulse_pwm(1); tick(6);
    check("R3 pwm 1 trigger", 32'(dac_code), 32'h0C2);
    wait_idle();
  endtask

  task automatic t_pin();
    int rises;
    logic prev;
    wr(1, 32'h0D1);
    wr(0, 1 | (1 << 5) | (3 << 8));
    @(negedge clk); ext_pin = 1'b1; tick(6);
    check("R4 rising edge trigger", 32'(dac_code), 32'h0D1);
    wait_idle();
    wr(1, 32'h0D2);
    wr(0, 1 | (1 << 5) | (2 << 8));
    tick(6);
    check("R4 falling mode quiet on steady high", 32'(dac_code), 32'h0D1);
    @(negedge clk); ext_pin = 1'b0; tick(6);
    check("R4 falling edge trigger", 32'(dac_code), 32'h0D2);
    wait_idle();
    wr(1, 32'h0E4);
    wr(0, 1 | (1 << 5) | (1 << 8));
    tick(6);
    check("R4 high level inactive", 32'(dac_code), 32'h0D2);
    @(negedge clk); ext_pin = 1'b1;
    rises = 0; prev = busy;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy && !prev) rises++;
      prev = busy;
    end
    check("R4 high level trigger", 32'(dac_code), 32'h0E4);
    check("R9 level re-fires", 32'(rises >= 8), 1);
    ext_pin = 1'b0; tick(8); wait_idle(); tick(6);
    check("R9 stops when level drops", 32'(busy), 0);
    wr(1, 32'h0D3);
    wr(0, 1 | (1 << 5));
    tick(6);
    check("R4 low level trigger", 32'(dac_code), 32'h0D3);
    ext_pin = 1'b1; tick(8); wait_idle();
  endtask

  task automatic t_dma();
    logic [31:0] v;
    wr(3, 3);
    wr(0, 4);
    wr(1, 32'h0F0);
    tick(3);
    check("R10 no request on data write start", 32'(dma_req), 0);
    wait_idle();
    wr(0, 1 | 4 | 16 | (2 << 5));
    wr(1, 32'h0F1);
    pulse_tmr(0); tick(6);
    check("R10 request on timer trigger", 32'(dma_req), 1);
    check("R10 code from timer start", 32'(dac_code), 32'h0F1);
    rd(3, v); check("R11 no under-run yet", v[1], 0);
    wait_idle();
    wr(1, 32'h0F2);
    check("R10 data write clears request", 32'(dma_req), 0);
    pulse_tmr(0); tick(6);
    wait_idle();
    rd(3, v); check("R11 answered request no under-run", v[1], 0);
    check("R11 irq quiet", 32'(irq), 0);
    pulse_tmr(0); tick(6);
    rd(3, v); check("R11 under-run flagged", v[1], 1);
    check("R11 under-run irq", 32'(irq), 1);
    wait_idle();
    wr(3, 2);
    rd(3, v); check("R11 W1C clears under-run", v[1], 0);
    check("R11 irq drops", 32'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_direct();
    t_left();
    t_busy_ignore();
    t_fin_irq();
    t_sw();
    t_timer_pwm();
    t_pin();
    t_dma();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule